// File: doc/BRIEF.md
# Wide Packed-BCD Adder with Parallel Correction Path

This block adds two packed BCD operands of `DIGITS` decimal digits and a decimal carry-in. It produces a packed BCD sum of the same width and a decimal carry-out. It is purely combinational and has no clock or reset.

It does not chain a corrected single-digit adder per digit. Two binary adders of full word width run side by side, so each maps onto one continuous carry chain.
- The plain adder forms A + B + cin.
- The correction adder forms A + B + cin plus six in every digit position.

Both adders expose the carry at every 4-bit boundary. For each digit, a small selector then takes one of two values:
- the correction-path digit, when that digit produced a decimal carry;
- otherwise, the plain-path digit, realigned by the difference between the two paths' incoming nibble carries.

The block's carry-out is the top nibble carry of the correction path. Input digits above nine are outside the contract, and the result for them is undefined.

Top module: `bcd_wide_adder`

## Requirements
- R1: For valid BCD inputs, every result digit equals the decimal sum digit: digit i of `sum_o` is (A_i + B_i + k_i) mod 10. Here k_0 = `cin_i`, and k_(i+1) is 1 exactly when A_i + B_i + k_i >= 10. Digit i occupies bits [4i+3:4i], with digit 0 the least significant.
- R2: `cout_o` is 1 exactly when the decimal value of A + B + `cin_i` is at least 10^DIGITS.
- R3: A set `cin_i` adds exactly one unit to the least significant digit. For example, 0 + 0 + 1 gives a sum of 1 with `cout_o` = 0.
- R4: For valid BCD inputs, every 4-bit digit of `sum_o` is in the range 0 to 9.
- R5: 0 + 0 with `cin_i` = 0 gives a sum of 0 with `cout_o` = 0.
- R6: All-nines plus all-nines plus carry-in gives all-nines with `cout_o` = 1.
- R7: All-nines plus zero plus carry-in ripples a carry through every digit, giving a sum of 0 with `cout_o` = 1.
- R8: The outputs follow a change of any input within the same clock period, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 4*DIGITS | First packed BCD operand |
| opb_i | input | 4*DIGITS | Second packed BCD operand |
| cin_i | input | 1 | Decimal carry-in |
| sum_o | output | 4*DIGITS | Packed BCD sum |
| cout_o | output | 1 | Decimal carry-out |

## Verification
Two things can coincide within one addition:
- a digit whose own sum needs the plus-six correction;
- an incoming carry that the plain and correction paths disagree on, for example 5+5 feeding a 0+0 digit.

The two-digit instance is driven over every valid operand pair, with both carry-in values, so every combination of local correction and incoming carry disagreement occurs. Each result is judged against an integer decimal reference. The four-digit instance adds random operands and chained cases such as 9999+0000+1 and 9999+9999+1, where a carry must pass through digits that are themselves corrected.

// File: rtl/bcdw_pkg.sv
package bcdw_pkg;

    localparam int NIB_W = 4;
    localparam logic [NIB_W-1:0] SIX = 4'd6;

    typedef logic [NIB_W-1:0] digit_t;

endpackage

// File: rtl/bcdw_chain_adder.sv
// Full-width binary adder built nibble by nibble so that the carry at each
// 4-bit boundary is visible. ADD_SIX selects the correction variant.
module bcdw_chain_adder #(
    parameter int DIGITS  = 4,
    parameter bit ADD_SIX = 1'b0,
    localparam int W      = 4*DIGITS
) (
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  logic            c_i,
    output logic [W-1:0]    s_o,
    output logic [DIGITS:0] nib_c_o
);
    import bcdw_pkg::*;

    assign nib_c_o[0] = c_i;

    for (genvar g = 0; g < DIGITS; g++) begin : g_nib
        logic [NIB_W:0] part;
        if (ADD_SIX) begin : g_six
            assign part = {1'b0, a_i[g*NIB_W +: NIB_W]}
                        + {1'b0, b_i[g*NIB_W +: NIB_W]}
                        + {1'b0, SIX}
                        + {{NIB_W{1'b0}}, nib_c_o[g]};
        end else begin : g_plain
            assign part = {1'b0, a_i[g*NIB_W +: NIB_W]}
                        + {1'b0, b_i[g*NIB_W +: NIB_W]}
                        + {{NIB_W{1'b0}}, nib_c_o[g]};
        end
        assign s_o[g*NIB_W +: NIB_W] = part[NIB_W-1:0];
        assign nib_c_o[g+1]          = part[NIB_W];
    end

endmodule

// File: rtl/bcdw_digit_pick.sv
// Per-digit selector: corrected digit when the digit carried, otherwise the
// plain digit realigned by the carry disagreement between the two paths.
module bcdw_digit_pick (
    input  bcdw_pkg::digit_t plain_d_i,
    input  bcdw_pkg::digit_t corr_d_i,
    input  logic             plain_cin_i,
    input  logic             corr_cin_i,
    input  logic             corr_cout_i,
    output bcdw_pkg::digit_t res_o
);
    import bcdw_pkg::*;

    digit_t realigned;
    logic   lag;

    // For valid BCD the plain carry never leads the corrected one, so the
    // difference is 0 or +1.
    assign lag       = corr_cin_i & ~plain_cin_i;
    assign realigned = plain_d_i + {{(NIB_W-1){1'b0}}, lag};

    always_comb begin
        if (corr_cout_i) res_o = corr_d_i;
        else             res_o = realigned;
    end

endmodule

// File: rtl/bcd_wide_adder.sv
module bcd_wide_adder #(
    parameter int DIGITS = 4,
    localparam int W     = 4*DIGITS
) (
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    import bcdw_pkg::*;

    logic [W-1:0]    plain_s, corr_s;
    logic [DIGITS:0] plain_c, corr_c;

    bcdw_chain_adder #(.DIGITS(DIGITS), .ADD_SIX(1'b0)) u_plain (
        .a_i(opa_i), .b_i(opb_i), .c_i(cin_i),
        .s_o(plain_s), .nib_c_o(plain_c)
    );

    bcdw_chain_adder #(.DIGITS(DIGITS), .ADD_SIX(1'b1)) u_corr (
        .a_i(opa_i), .b_i(opb_i), .c_i(cin_i),
        .s_o(corr_s), .nib_c_o(corr_c)
    );

    for (genvar g = 0; g < DIGITS; g++) begin : g_pick
        bcdw_digit_pick u_pick (
            .plain_d_i  (plain_s[g*NIB_W +: NIB_W]),
            .corr_d_i   (corr_s[g*NIB_W +: NIB_W]),
            .plain_cin_i(plain_c[g]),
            .corr_cin_i (corr_c[g]),
            .corr_cout_i(corr_c[g+1]),
            .res_o      (sum_o[g*NIB_W +: NIB_W])
        );
    end

    // A plain top carry always implies a corrected top carry for valid BCD.
    assign cout_o = corr_c[DIGITS] | plain_c[DIGITS];

endmodule

// File: rtl/bcd_wide_adder_chk.sv
module bcd_wide_adder_chk #(
    parameter int DIGITS = 4,
    localparam int W     = 4*DIGITS
) (
    input logic [W-1:0] opa_i,
    input logic [W-1:0] opb_i,
    input logic         cin_i,
    input logic [W-1:0] sum_o,
    input logic         cout_o
);
    localparam logic [W-1:0] NINES = {DIGITS{4'h9}};
    localparam logic [W-1:0] ONE   = {{(W-1){1'b0}}, 1'b1};

    function automatic bit all_valid(input logic [W-1:0] v);
        bit ok = 1'b1;
        for (int i = 0; i < DIGITS; i++)
            if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
        return ok;
    endfunction

    always_comb begin
        // R4
        digits_valid_chk: assert (!(all_valid(opa_i) && all_valid(opb_i)) || all_valid(sum_o));
        // R5
        zero_sum_chk: assert (!(opa_i == '0 && opb_i == '0 && !cin_i) || (sum_o == '0 && !cout_o));
        // R3
        unit_cin_chk: assert (!(opa_i == '0 && opb_i == '0 && cin_i) || (sum_o == ONE && !cout_o));
        // R6
        max_corner_chk: assert (!(opa_i == NINES && opb_i == NINES && cin_i) || (sum_o == NINES && cout_o));
        // R7
        full_ripple_chk: assert (!(opa_i == NINES && opb_i == '0 && cin_i) || (sum_o == '0 && cout_o));
    end

endmodule

bind bcd_wide_adder bcd_wide_adder_chk #(.DIGITS(DIGITS)) u_chk (
    .opa_i(opa_i), .opb_i(opb_i), .cin_i(cin_i), .sum_o(sum_o), .cout_o(cout_o)
);

// File: tb/bcd_wide_adder_test.sv
`timescale 1ns/1ps
module bcd_wide_adder_test;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    int total = 0;
    int bad   = 0;

    logic [15:0] a4 = '0, b4 = '0, s4;
    logic        c4 = 1'b0, co4;
    logic [7:0]  a2 = '0, b2 = '0, s2;
    logic        c2 = 1'b0, co2;

    bcd_wide_adder #(.DIGITS(4)) uut (
        .opa_i(a4), .opb_i(b4), .cin_i(c4), .sum_o(s4), .cout_o(co4)
    );
    bcd_wide_adder #(.DIGITS(2)) uut_narrow (
        .opa_i(a2), .opb_i(b2), .cin_i(c2), .sum_o(s2), .cout_o(co2)
    );

    function automatic int from_bcd(input logic [15:0] v, input int nd);
        int r = 0;
        for (int i = nd-1; i >= 0; i--) r = r*10 + int'(v[i*4 +: 4]);
        return r;
    endfunction

    function automatic logic [15:0] to_bcd(input int v, input int nd);
        logic [15:0] r = '0;
        int x = v;
        for (int i = 0; i < nd; i++) begin
            r[i*4 +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    function automatic logic [15:0] rand_bcd(input int nd);
        logic [15:0] r = '0;
        for (int i = 0; i < nd; i++) r[i*4 +: 4] = 4'($urandom_range(0, 9));
        return r;
    endfunction

    task automatic check(input string req, input int nd,
                         input logic [15:0] a, input logic [15:0] b, input logic cin,
                         input logic [15:0] got, input logic got_c);
        int lim = (nd == 4) ? 10000 : 100;
        int tot = from_bcd(a, nd) + from_bcd(b, nd) + int'(cin);
        logic [15:0] exp_s = to_bcd(tot % lim, nd);
        logic exp_c = (tot >= lim);
        bit digits_ok = 1'b1;
        for (int i = 0; i < nd; i++) if (got[i*4 +: 4] > 4'd9) digits_ok = 1'b0;
        total++;
        if (got != exp_s) begin
            bad++;
            $display("FAIL %s/R1 sum: a=%h b=%h cin=%0d actual=%h expected=%h", req, a, b, cin, got, exp_s);
        end
        total++;
        if (got_c != exp_c) begin
            bad++;
            $display("FAIL %s/R2 carry: a=%h b=%h cin=%0d actual=%0d expected=%0d", req, a, b, cin, got_c, exp_c);
        end
        total++;
        if (!digits_ok) begin
            bad++;
            $display("FAIL R4 digit range: a=%h b=%h actual=%h expected=all digits<=9", a, b, got);
        end
    endtask

    task automatic apply4(input string req, input logic [15:0] a, input logic [15:0] b, input logic cin);
        @(posedge clk);
        a4 = a; b4 = b; c4 = cin;
        @(negedge clk);
        check(req, 4, a, b, cin, s4, co4);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        // R5: initial all-zero inputs
        check("R5", 4, a4, b4, c4, s4, co4);

        apply4("R5", 16'h0000, 16'h0000, 1'b0);
        apply4("R3", 16'h0000, 16'h0000, 1'b1);
        apply4("R3", 16'h1234, 16'h4321, 1'b1);
        apply4("R6", 16'h9999, 16'h9999, 1'b1);
        apply4("R6", 16'h9999, 16'h9999, 1'b0);
        apply4("R7", 16'h9999, 16'h0000, 1'b1);
        apply4("R7", 16'h0000, 16'h9999, 1'b1);
        apply4("R1", 16'h0505, 16'h0505, 1'b0);
        apply4("R1", 16'h0999, 16'h0001, 1'b0);
        apply4("R2", 16'h5000, 16'h5000, 1'b0);
        apply4("R2", 16'h4999, 16'h5000, 1'b1);

        // R8: mid-cycle input change, output follows without a clock edge
        @(posedge clk);
        #1.0;
        a4 = 16'h0048; b4 = 16'h0052; c4 = 1'b0;
        #0.5;
        check("R8", 4, a4, b4, c4, s4, co4);

        // R1 R2 R4: exhaustive two-digit sweep
        for (int cin = 0; cin < 2; cin++) begin
            for (int x = 0; x < 100; x++) begin
                for (int y = 0; y < 100; y++) begin
                    @(posedge clk);
                    a2 = to_bcd(x, 2)[7:0];
                    b2 = to_bcd(y, 2)[7:0];
                    c2 = cin[0];
                    @(negedge clk);
                    check("R1", 2, {8'h00, a2}, {8'h00, b2}, c2, {8'h00, s2}, co2);
                end
            end
        end

        // R1 R2 R4: random four-digit operands
        for (int n = 0; n < 3000; n++)
            apply4("R1", rand_bcd(4), rand_bcd(4), 1'($urandom_range(0, 1)));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule